// File: doc/BRIEF.md
# Hardware Address/Data Breakpoint Unit

This block sits beside a CPU core and watches its memory bus: the 16-bit address, eight extended page-address bits, the 16-bit data and the read/write direction. Three comparators look for programmed patterns. Comparators A and B form a pair. In one mode they are two independent address breakpoints. In the other mode they form one breakpoint that needs both an address match and a data match. Comparator C is a third address breakpoint. It can also qualify its match with extended page-address bits and with the bus direction.

A hit produces a one-cycle break request and a cause flag. The flag says whether the core should enter background debug or take a software interrupt. Each comparator group works in one of two ways. In force mode a hit breaks at the next instruction boundary. In tagged mode a hit during an opcode fetch only marks that opcode. The mark travels through a short tag queue that follows the fetch queue. The break fires when the opcode executes. If the opcode is flushed first, the mark is dropped and no break happens.

Software programs the unit through a 16-bit register port with one shared address. Reads are combinational. The capture-control input strobe from the trace logic is modelled only as far as it touches these registers.

Top module: `hw_break_unit`

## Requirements
- R1: After a synchronous reset, every register reads back 0 and `brk_req` is low.
- R2: Register 5 bit 0 is the capture enable. A write that would set it is ignored while the A/B enable (register 0 bit 0) is 1. Otherwise the write takes effect.
- R3: Register 0 bit 1 is the full-mode bit. At 0, comparators A (register 2) and B (register 3) each hit when the bus address equals their value. When register 0 bit 0 is 0, A and B never hit, whatever the full-mode and A/B tag bits hold.
- R4: At full mode 1, the A/B pair hits only when the address equals register 2 and, in the same cycle, the data equals register 3.
- R5: With the group tag bit at 0 (A/B tag is register 0 bit 3, C tag is bit 5), a hit sets a pending break. The first later cycle with `instr_boundary` high causes `brk_req` to be high for exactly the following cycle.
- R6: With the group tag bit at 1, a hit counts only on a cycle with `bus_fetch` high. It marks that fetch in the tag queue and does not set a pending break. `brk_req` rises in the cycle after `exec_pop` retires the marked entry. Entries retire in fetch order.
- R7: `flush` empties the tag queue. A marked entry that is flushed, including one flushed in the same cycle as `exec_pop`, never raises `brk_req`.
- R8: `brk_bgnd` accompanies each request and equals register 0 bit 2 as it stood in the cycle the break fell due. 1 means background debug and 0 means software interrupt.
- R9: Register 0 bit 4 enables comparator C. A cycle with `arm_loop1` high clears it, and the other control bits are left unchanged.
- R10: Register 1 bits 1:0 select the page mode of C and bits 13:8 hold a 6-bit page value. The low byte of register 4 must equal `bus_addr[7:0]`. For modes 0, 2 and 3, the high byte must equal `bus_addr[15:8]`. For mode 1, it must equal {`bus_ext[1:0]`, `bus_addr[13:8]`}. Mode 3 also needs `bus_ext[7:2]` to equal the page value.
- R11: Register 0 bit 6 enables the direction check for C. When it is set, C also needs `bus_rw` to equal register 0 bit 7.
- R12: No comparator hits in a cycle where `bus_valid` is low.
- R13: When a forced break and a tagged break fall due in the same cycle, `brk_req` is high for a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select for writes and reads |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Readback of the selected register |
| arm_loop1 | input | 1 | Capture logic armed in loop1 mode; clears C enable |
| bus_valid | input | 1 | Bus cycle qualifier |
| bus_fetch | input | 1 | Cycle is an opcode fetch entering the fetch queue |
| bus_rw | input | 1 | Bus direction (1 read, 0 write) |
| bus_ext | input | 8 | Extended address bits 21:14 |
| bus_addr | input | 16 | Address bits 15:0 |
| bus_data | input | 16 | Data bus |
| instr_boundary | input | 1 | Instruction boundary strobe |
| exec_pop | input | 1 | Oldest queued opcode executes |
| flush | input | 1 | Fetch queue discarded |
| brk_req | output | 1 | One-cycle break request |
| brk_bgnd | output | 1 | Cause: 1 background debug, 0 software interrupt |

## Verification
The bench sweeps comparator C over all four page modes against addresses and extended bits chosen so that each mode matches a different subset. If the mode-1 byte were assembled from the wrong address bits, or the mode-3 page check were applied in every mode, the expected and actual break pattern would differ. It also sweeps the A/B pair through dual, full and disabled settings with address and data values taken from both comparators. This exposes a design that crosses A and B or lets the full-mode bit act while the pair is off. In tagged mode, an untagged fetch is queued ahead of a tagged one. A queue that retires in the wrong order would break on the wrong pop, and one that forgets flushes would break after a flush. Other directed cases cover: a capture-enable write blocked by the A/B enable; C enable cleared by a loop1 arm; a forced and a tagged break falling due together, which must give one pulse and not two.

// File: rtl/hw_break_pkg.sv
package hw_break_pkg;

    localparam int BUS_W   = 16;
    localparam int EXT_W   = 8;
    localparam int XCMP_W  = 6;
    localparam int REG_AW  = 3;
    localparam int BYTE_W  = 8;
    localparam int WIN_W   = EXT_W - XCMP_W;

    typedef enum logic [1:0] {
        PG_NONE   = 2'd0,
        PG_WINDOW = 2'd1,
        PG_PLAIN  = 2'd2,
        PG_EXTHI  = 2'd3
    } page_sel_e;

    typedef enum logic [REG_AW-1:0] {
        RA_CTRL = 3'd0,
        RA_PAGE = 3'd1,
        RA_CMPA = 3'd2,
        RA_CMPB = 3'd3,
        RA_CMPC = 3'd4,
        RA_CAPT = 3'd5
    } reg_addr_e;

    // packed: first member is the most significant bit (bit 7)
    typedef struct packed {
        logic rw_val;
        logic rw_cmp_en;
        logic tag_c;
        logic c_en;
        logic tag_ab;
        logic to_bgnd;
        logic full_mode;
        logic ab_en;
    } ctrl_t;

    typedef struct packed {
        ctrl_t              ctrl;
        page_sel_e          page;
        logic [XCMP_W-1:0]  xcmp;
        logic [BUS_W-1:0]   cmp_a;
        logic [BUS_W-1:0]   cmp_b;
        logic [BUS_W-1:0]   cmp_c;
        logic               cap_en;
    } cfg_t;

    typedef struct packed {
        logic              valid;
        logic              fetch;
        logic              rw;
        logic [EXT_W-1:0]  ext;
        logic [BUS_W-1:0]  addr;
        logic [BUS_W-1:0]  data;
    } bus_t;

    typedef struct packed {
        logic force_hit;
        logic tag_hit;
    } hit_t;

    // high byte that comparator C sees, per page mode
    function automatic logic [BYTE_W-1:0] c_high_byte(page_sel_e s,
                                                      logic [BUS_W-1:0] a,
                                                      logic [EXT_W-1:0] x);
        if (s == PG_WINDOW)
            return {x[WIN_W-1:0], a[BUS_W-WIN_W-1:BYTE_W]};
        return a[BUS_W-1:BYTE_W];
    endfunction

    function automatic logic c_page_ok(page_sel_e s,
                                       logic [EXT_W-1:0] x,
                                       logic [XCMP_W-1:0] v);
        return (s != PG_EXTHI) || (x[EXT_W-1 -: XCMP_W] == v);
    endfunction

endpackage

// File: rtl/brk_regs.sv
module brk_regs
    import hw_break_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [REG_AW-1:0]  addr,
    input  logic [BUS_W-1:0]   wdata,
    input  logic               arm_loop1,
    output cfg_t               cfg,
    output logic [BUS_W-1:0]   rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else begin
            if (we) begin
                case (reg_addr_e'(addr))
                    RA_CTRL: cfg.ctrl  <= ctrl_t'(wdata[BYTE_W-1:0]);
                    RA_PAGE: begin
                        cfg.page <= page_sel_e'(wdata[1:0]);
                        cfg.xcmp <= wdata[BYTE_W +: XCMP_W];
                    end
                    RA_CMPA: cfg.cmp_a <= wdata;
                    RA_CMPB: cfg.cmp_b <= wdata;
                    RA_CMPC: cfg.cmp_c <= wdata;
                    RA_CAPT: begin
                        // setting capture is refused while A/B breakpoints own the comparators
                        if (!cfg.ctrl.ab_en || !wdata[0])
                            cfg.cap_en <= wdata[0];
                    end
                    default: ;
                endcase
            end
            if (arm_loop1)
                cfg.ctrl.c_en <= 1'b0;
        end
    end

    always_comb begin
        case (reg_addr_e'(addr))
            RA_CTRL: rdata = BUS_W'(cfg.ctrl);
            RA_PAGE: rdata = BUS_W'({cfg.xcmp, {(BYTE_W-2){1'b0}}, cfg.page});
            RA_CMPA: rdata = cfg.cmp_a;
            RA_CMPB: rdata = cfg.cmp_b;
            RA_CMPC: rdata = cfg.cmp_c;
            RA_CAPT: rdata = BUS_W'(cfg.cap_en);
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/brk_match.sv
module brk_match
    import hw_break_pkg::*;
(
    input  cfg_t  cfg,
    input  bus_t  bus,
    output hit_t  hit
);

    logic a_addr, b_addr, b_data, ab_match;
    logic c_lo_ok, c_hi_ok, c_pg_ok, c_rw_ok, c_match;
    logic ab_force, ab_tag, c_force, c_tag;
    logic unused_cfg;

    assign unused_cfg = ^{cfg.cap_en, cfg.ctrl.to_bgnd};

    always_comb begin
        a_addr   = (bus.addr == cfg.cmp_a);
        b_addr   = (bus.addr == cfg.cmp_b);
        b_data   = (bus.data == cfg.cmp_b);
        ab_match = cfg.ctrl.ab_en &&
                   (cfg.ctrl.full_mode ? (a_addr && b_data) : (a_addr || b_addr));

        c_lo_ok  = (bus.addr[BYTE_W-1:0] == cfg.cmp_c[BYTE_W-1:0]);
        c_hi_ok  = (c_high_byte(cfg.page, bus.addr, bus.ext) == cfg.cmp_c[BUS_W-1:BYTE_W]);
        c_pg_ok  = c_page_ok(cfg.page, bus.ext, cfg.xcmp);
        c_rw_ok  = !cfg.ctrl.rw_cmp_en || (bus.rw == cfg.ctrl.rw_val);
        c_match  = cfg.ctrl.c_en && c_lo_ok && c_hi_ok && c_pg_ok && c_rw_ok;

        ab_force = ab_match && !cfg.ctrl.tag_ab;
        ab_tag   = ab_match &&  cfg.ctrl.tag_ab;
        c_force  = c_match  && !cfg.ctrl.tag_c;
        c_tag    = c_match  &&  cfg.ctrl.tag_c;

        hit.force_hit = bus.valid && (ab_force || c_force);
        hit.tag_hit   = bus.valid && bus.fetch && (ab_tag || c_tag);
    end

endmodule

// File: rtl/brk_tagq.sv
module brk_tagq #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  logic tag_in,
    input  logic pop_req,
    input  logic flush,
    output logic tag_due
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DEPTH-1:0] tag_q, tag_d;
    logic [DEPTH:0]   tag_ext;
    logic [CNT_W-1:0] cnt_q, cnt_d, wr_idx;
    logic             pop, push_ok;

    always_comb begin
        pop     = pop_req && (cnt_q != '0);
        push_ok = push && ((cnt_q != CNT_W'(DEPTH)) || pop);
        wr_idx  = cnt_q - CNT_W'(pop);
        cnt_d   = cnt_q + CNT_W'(push_ok) - CNT_W'(pop);
        tag_ext = {1'b0, tag_q};
        for (int i = 0; i < DEPTH; i++) begin
            tag_d[i] = pop ? tag_ext[i+1] : tag_q[i];
            if (push_ok && (wr_idx == CNT_W'(i)))
                tag_d[i] = tag_in;
        end
    end

    assign tag_due = pop && tag_q[0] && !flush;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            cnt_q <= '0;
            tag_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            tag_q <= tag_d;
        end
    end

endmodule

// File: rtl/brk_issue.sv
module brk_issue (
    input  logic clk,
    input  logic rst,
    input  logic force_hit,
    input  logic boundary,
    input  logic tag_due,
    input  logic to_bgnd,
    output logic brk_req,
    output logic brk_bgnd
);

    logic pend_q, force_due, any_due;

    assign force_due = boundary && pend_q;
    assign any_due   = force_due || tag_due;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= 1'b0;
            brk_req  <= 1'b0;
            brk_bgnd <= 1'b0;
        end else begin
            pend_q  <= force_hit || (pend_q && !force_due);
            brk_req <= any_due;
            if (any_due)
                brk_bgnd <= to_bgnd;
        end
    end

endmodule

// File: rtl/hw_break_unit.sv
module hw_break_unit
    import hw_break_pkg::*;
#(
    parameter int QDEPTH = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [REG_AW-1:0]  cfg_addr,
    input  logic [BUS_W-1:0]   cfg_wdata,
    output logic [BUS_W-1:0]   cfg_rdata,
    input  logic               arm_loop1,
    input  logic               bus_valid,
    input  logic               bus_fetch,
    input  logic               bus_rw,
    input  logic [EXT_W-1:0]   bus_ext,
    input  logic [BUS_W-1:0]   bus_addr,
    input  logic [BUS_W-1:0]   bus_data,
    input  logic               instr_boundary,
    input  logic               exec_pop,
    input  logic               flush,
    output logic               brk_req,
    output logic               brk_bgnd
);

    cfg_t cfg;
    bus_t bus;
    hit_t hit;
    logic tag_due;

    always_comb begin
        bus.valid = bus_valid;
        bus.fetch = bus_fetch;
        bus.rw    = bus_rw;
        bus.ext   = bus_ext;
        bus.addr  = bus_addr;
        bus.data  = bus_data;
    end

    brk_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .arm_loop1 (arm_loop1),
        .cfg       (cfg),
        .rdata     (cfg_rdata)
    );

    brk_match u_match (
        .cfg (cfg),
        .bus (bus),
        .hit (hit)
    );

    brk_tagq #(.DEPTH(QDEPTH)) u_tagq (
        .clk     (clk),
        .rst     (rst),
        .push    (bus_valid && bus_fetch),
        .tag_in  (hit.tag_hit),
        .pop_req (exec_pop),
        .flush   (flush),
        .tag_due (tag_due)
    );

    brk_issue u_issue (
        .clk       (clk),
        .rst       (rst),
        .force_hit (hit.force_hit),
        .boundary  (instr_boundary),
        .tag_due   (tag_due),
        .to_bgnd   (cfg.ctrl.to_bgnd),
        .brk_req   (brk_req),
        .brk_bgnd  (brk_bgnd)
    );

endmodule

// File: rtl/brk_checker.sv
module brk_checker
    import hw_break_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic arm_loop1,
    input logic instr_boundary,
    input logic exec_pop,
    input logic flush,
    input logic brk_req,
    input logic brk_bgnd,
    input cfg_t cfg
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!brk_req && cfg == '0));

    assert_capture_blocked_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg.cap_en) |-> !$past(cfg.ctrl.ab_en));

    // R5, R6: a request only follows a boundary or an execute strobe
    assert_req_has_cause_R5: assert property (@(posedge clk) disable iff (rst)
        brk_req |-> ($past(instr_boundary) || $past(exec_pop)));

    assert_flush_kills_tag_R7: assert property (@(posedge clk) disable iff (rst)
        (flush && !instr_boundary) |=> !brk_req);

    assert_cause_follows_ctrl_R8: assert property (@(posedge clk) disable iff (rst)
        brk_req |-> (brk_bgnd == $past(cfg.ctrl.to_bgnd)));

    assert_loop1_clears_c_R9: assert property (@(posedge clk) disable iff (rst)
        arm_loop1 |=> !cfg.ctrl.c_en);

endmodule

bind hw_break_unit brk_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .arm_loop1      (arm_loop1),
    .instr_boundary (instr_boundary),
    .exec_pop       (exec_pop),
    .flush          (flush),
    .brk_req        (brk_req),
    .brk_bgnd       (brk_bgnd),
    .cfg            (cfg)
);

// File: tb/sim_hw_break_unit.sv
module sim_hw_break_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = 3'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic [15:0] cfg_rdata;
    logic        arm_loop1 = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_fetch = 1'b0;
    logic        bus_rw = 1'b0;
    logic [7:0]  bus_ext = 8'd0;
    logic [15:0] bus_addr = 16'd0;
    logic [15:0] bus_data = 16'd0;
    logic        instr_boundary = 1'b0;
    logic        exec_pop = 1'b0;
    logic        flush = 1'b0;
    logic        brk_req;
    logic        brk_bgnd;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    hw_break_unit u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .arm_loop1(arm_loop1),
        .bus_valid(bus_valid), .bus_fetch(bus_fetch), .bus_rw(bus_rw),
        .bus_ext(bus_ext), .bus_addr(bus_addr), .bus_data(bus_data),
        .instr_boundary(instr_boundary), .exec_pop(exec_pop), .flush(flush),
        .brk_req(brk_req), .brk_bgnd(brk_bgnd)
    );

    localparam logic [15:0] CA = 16'h1234;
    localparam logic [15:0] CB = 16'h4321;
    localparam logic [15:0] CC = 16'h5A3C;
    localparam logic [5:0]  XV = 6'h2B;

    task automatic chkb(input string req, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic chkw(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        cfg_addr = a;
        #1 v = cfg_rdata;
    endtask

    // one bus cycle, then a boundary; returns the request seen after it
    task automatic probe(input logic [15:0] a, input logic [15:0] d, input logic [7:0] x,
                         input logic rw, input logic v, output logic got, output logic cause);
        @(negedge clk);
        bus_valid = v; bus_addr = a; bus_data = d; bus_ext = x; bus_rw = rw;
        @(negedge clk);
        bus_valid = 1'b0; instr_boundary = 1'b1;
        @(negedge clk);
        instr_boundary = 1'b0;
        got = brk_req; cause = brk_bgnd;
        @(negedge clk);
        chkb("R5 single pulse", brk_req, 1'b0);
    endtask

    task automatic fetch(input logic [15:0] a);
        @(negedge clk);
        bus_valid = 1'b1; bus_fetch = 1'b1; bus_addr = a; bus_ext = 8'h00; bus_rw = 1'b1;
        @(negedge clk);
        bus_valid = 1'b0; bus_fetch = 1'b0;
    endtask

    function automatic logic exp_c(input int sel, input logic [15:0] a, input logic [7:0] x,
                                   input logic rwen, input logic rwv, input logic rw);
        logic [7:0] hi;
        hi = (sel == 1) ? {x[1:0], a[13:8]} : a[15:8];
        return (hi == CC[15:8]) && (a[7:0] == CC[7:0]) &&
               ((sel != 3) || (x[7:2] == XV)) && (!rwen || (rw == rwv));
    endfunction

    initial begin
        repeat (300000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic got, cause;
        logic [15:0] alist [4];
        logic [7:0]  xlist [4];
        logic [15:0] ablist [3];
        logic [15:0] dlist [3];
        alist = '{16'h5A3C, 16'h1A3C, 16'h5A3D, 16'h9A3C};
        xlist = '{8'hAD, 8'hAE, 8'hA9, 8'h00};
        ablist = '{CA, CB, 16'h0777};
        dlist = '{CA, CB, 16'h0BAD};

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int r = 0; r < 6; r++) begin
            rd(3'(r), v);
            chkw("R1 reset readback", v, 16'h0000);
        end
        chkb("R1 reset brk_req", brk_req, 1'b0);

        // R2 capture enable blocking
        wr(3'd0, 16'h0001);
        wr(3'd5, 16'h0001);
        rd(3'd5, v);
        chkw("R2 capture blocked", v, 16'h0000);
        wr(3'd0, 16'h0000);
        wr(3'd5, 16'h0001);
        rd(3'd5, v);
        chkw("R2 capture accepted", v, 16'h0001);
        wr(3'd5, 16'h0000);

        // R3 R4 A/B sweep, R12 via valid low
        wr(3'd2, CA);
        wr(3'd3, CB);
        for (int en = 0; en < 2; en++) begin
            for (int fm = 0; fm < 2; fm++) begin
                wr(3'd0, 16'((en != 0 ? 1 : 0) | (fm != 0 ? 2 : 0) | (en == 0 ? 8 : 0)));
                for (int ai = 0; ai < 3; ai++) begin
                    for (int di = 0; di < 3; di++) begin
                        logic e;
                        e = (en != 0) && ((fm != 0) ? (ablist[ai] == CA && dlist[di] == CB)
                                                    : (ablist[ai] == CA || ablist[ai] == CB));
                        probe(ablist[ai], dlist[di], 8'h00, 1'b0, 1'b1, got, cause);
                        if (fm != 0) chkb("R4 full mode", got, e);
                        else         chkb("R3 dual mode", got, e);
                    end
                end
            end
        end
        wr(3'd0, 16'h0001);
        probe(CA, 16'h0, 8'h00, 1'b0, 1'b0, got, cause);
        chkb("R12 valid low", got, 1'b0);

        // R8 cause
        probe(CA, 16'h0, 8'h00, 1'b0, 1'b1, got, cause);
        chkb("R8 swi request", got, 1'b1);
        chkb("R8 swi cause", cause, 1'b0);
        wr(3'd0, 16'h0005);
        probe(CB, 16'h0, 8'h00, 1'b0, 1'b1, got, cause);
        chkb("R8 bgnd request", got, 1'b1);
        chkb("R8 bgnd cause", cause, 1'b1);

        // R10 page modes on comparator C
        wr(3'd4, CC);
        wr(3'd0, 16'h0010);
        for (int s = 0; s < 4; s++) begin
            wr(3'd1, {2'b00, XV, 6'b000000, 2'(s)});
            for (int ai = 0; ai < 4; ai++) begin
                for (int xi = 0; xi < 4; xi++) begin
                    probe(alist[ai], 16'h0, xlist[xi], 1'b0, 1'b1, got, cause);
                    chkb("R10 page compare", got, exp_c(s, alist[ai], xlist[xi], 1'b0, 1'b0, 1'b0));
                end
            end
        end

        // R11 direction compare
        wr(3'd1, 16'h0002);
        for (int en = 0; en < 2; en++) begin
            wr(3'd0, 16'(16'h0090 | (en != 0 ? 16'h0040 : 16'h0000)));
            for (int rw = 0; rw < 2; rw++) begin
                probe(CC, 16'h0, 8'h00, 1'(rw), 1'b1, got, cause);
                chkb("R11 rw compare", got, exp_c(2, CC, 8'h00, 1'(en), 1'b1, 1'(rw)));
            end
        end

        // R9 loop1 arm clears C enable only
        wr(3'd0, 16'h0014);
        @(negedge clk); arm_loop1 = 1'b1;
        @(negedge clk); arm_loop1 = 1'b0;
        rd(3'd0, v);
        chkw("R9 c_en cleared", v, 16'h0004);
        probe(CC, 16'h0, 8'h00, 1'b0, 1'b1, got, cause);
        chkb("R9 C disabled", got, 1'b0);

        // R6 tagged ordering
        wr(3'd0, 16'h0009);
        fetch(16'h0100);
        fetch(CA);
        @(negedge clk); exec_pop = 1'b1;
        @(negedge clk); exec_pop = 1'b0;
        chkb("R6 untagged pop", brk_req, 1'b0);
        exec_pop = 1'b1;
        @(negedge clk); exec_pop = 1'b0;
        chkb("R6 tagged pop", brk_req, 1'b1);
        @(negedge clk); instr_boundary = 1'b1;
        @(negedge clk); instr_boundary = 1'b0;
        chkb("R6 tag sets no pending", brk_req, 1'b0);

        // R7 flush
        fetch(CA);
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0; exec_pop = 1'b1;
        @(negedge clk); exec_pop = 1'b0;
        chkb("R7 flushed tag", brk_req, 1'b0);
        fetch(CA);
        @(negedge clk); flush = 1'b1; exec_pop = 1'b1;
        @(negedge clk); flush = 1'b0; exec_pop = 1'b0;
        chkb("R7 flush with pop", brk_req, 1'b0);

        // R13 forced and tagged due together
        wr(3'd4, CA);
        wr(3'd0, 16'h0019);
        fetch(CA);
        @(negedge clk); exec_pop = 1'b1; instr_boundary = 1'b1;
        @(negedge clk); exec_pop = 1'b0; instr_boundary = 1'b0;
        chkb("R13 coincident request", brk_req, 1'b1);
        @(negedge clk);
        chkb("R13 single pulse", brk_req, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule